// File: doc/BRIEF.md
# Predicated Vector Compare Sequencer

This block runs a branch-class compare whose operands have been marked as vectors. It does not redirect the program counter. It walks the elements one per clock and builds a predicate bitfield, one bit per element, then writes that bitfield into a chosen target register. A vector operand supplies register `base + i` for element `i`. A scalar operand supplies the same register for every element, so it is broadcast against the vector side.

When neither operand is a vector, the block leaves the register file alone. It pulses a flag so that the pipeline takes its ordinary scalar branch path.

The surrounding pipeline drives the decoded fields and the vector length together with a one-cycle `start`. The two read ports are combinational: the block drives each address and samples the returned data in the same cycle. The target register number comes from the bits that normally hold the low part of the branch offset. The upper offset bits are unused, because the program counter does not move.

Top module: `vcmp_seq`

## Requirements
- R1: Compare code 3'b000 tests equality and 3'b001 tests inequality of the two element values.
- R2: Compare code 3'b100 tests signed less-than and 3'b101 tests signed greater-or-equal (first operand against second).
- R3: Compare code 3'b110 tests unsigned less-than and 3'b111 tests unsigned greater-or-equal.
- R4: Compare codes 3'b010 and 3'b011 are reserved. They evaluate false for every element, so the written mask is all zero.
- R5: During element `i`, a vector operand's read address is `(base + i) mod NREG` and a scalar operand's read address is its base. Element `i` is handled in the `i`-th cycle after the start cycle, counting from 0.
- R6: Bit `i` of the written mask is 1 exactly when element `i`'s compare is true. Bits at positions at or above the effective length are 0, and the accumulator starts from zero on every accepted start.
- R7: If both vector flags are 0, `scalar_take` is high for exactly one cycle, in the cycle after start. In that case `busy` stays low and no write occurs.
- R8: With effective length L > 0, `busy` is high for the L cycles that follow the start cycle. Then `wr_en` and `done` are high together for one cycle, with `wr_addr` equal to the target register number and `busy` low.
- R9: A length of 0 with a vector operand writes an all-zero mask in the cycle after start, and `busy` is never raised.
- R10: A requested length above XLEN is clamped to XLEN.
- R11: A `start` that arrives while a walk or write is in progress is ignored. The running operation's operands, target and result are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted only when idle |
| funct3 | input | 3 | Compare selector |
| src1_idx | input | AW | First operand base register |
| src2_idx | input | AW | Second operand base register |
| src1_vec | input | 1 | First operand is a vector |
| src2_vec | input | 1 | Second operand is a vector |
| pred_dst | input | AW | Target register for the mask |
| vl | input | VW | Requested vector length |
| rd1_addr | output | AW | Read address, first operand |
| rd1_data | input | XLEN | Read data, first operand |
| rd2_addr | output | AW | Read address, second operand |
| rd2_data | input | XLEN | Read data, second operand |
| wr_en | output | 1 | Mask write strobe |
| wr_addr | output | AW | Mask write register |
| wr_data | output | XLEN | Mask value |
| busy | output | 1 | Element walk in progress |
| done | output | 1 | Mask written this cycle |
| scalar_take | output | 1 | Both operands scalar: use the normal branch path |

## Verification
The directed tests go after these corner cases:
- Signed and unsigned orderings on values whose top bit differs. A swapped or missing `$signed` would flip those bits.
- A vector base near the top of the register file. An address generator that does not wrap would read out of range.
- Length zero. A design that is off by one here would raise `busy` or write a stale mask.
- A requested length above XLEN. Without the clamp, the walk would overrun or the latency would be wrong.
- A second `start` during a walk. If accepted, it would corrupt the target and the result.

The bench also checks that the mask comes out after exactly L+1 cycles, and that the all-scalar case neither writes nor raises `busy`.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WALK  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_t;

  localparam logic [2:0] CMP_EQ  = 3'b000;
  localparam logic [2:0] CMP_NE  = 3'b001;
  localparam logic [2:0] CMP_LT  = 3'b100;
  localparam logic [2:0] CMP_GE  = 3'b101;
  localparam logic [2:0] CMP_LTU = 3'b110;
  localparam logic [2:0] CMP_GEU = 3'b111;
endpackage

// File: rtl/vcmp_addr_gen.sv
module vcmp_addr_gen #(
  parameter int NREG = 32,
  parameter int IW   = 5,
  localparam int AW  = $clog2(NREG)
) (
  input  logic [AW-1:0] base,
  input  logic          is_vec,
  input  logic [IW-1:0] idx,
  output logic [AW-1:0] addr
);
  function automatic logic [AW-1:0] elem_addr(input logic [AW-1:0] b,
                                              input logic v,
                                              input logic [IW-1:0] i);
    int unsigned sum;
    if (!v) return b;
    sum = int'(b) + int'(i);
    return AW'(sum % NREG);
  endfunction

  assign addr = elem_addr(base, is_vec, idx);

  always_comb begin
    if (!is_vec)
      assert_scalar_fixed_R5: assert (addr == base);
  end
endmodule

// File: rtl/vcmp_elem_cmp.sv
module vcmp_elem_cmp
  import vcmp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2:0]      sel,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            hit
);
  function automatic logic cmp_eval(input logic [2:0] f,
                                    input logic [XLEN-1:0] x,
                                    input logic [XLEN-1:0] y);
    case (f)
      CMP_EQ:  return x == y;
      CMP_NE:  return x != y;
      CMP_LT:  return $signed(x) <  $signed(y);
      CMP_GE:  return $signed(x) >= $signed(y);
      CMP_LTU: return x <  y;
      CMP_GEU: return x >= y;
      default: return 1'b0;
    endcase
  endfunction

  assign hit = cmp_eval(sel, a, b);

  always_comb begin
    if (sel == 3'b010 || sel == 3'b011)
      assert_reserved_false_R4: assert (!hit);
  end
endmodule

// File: rtl/vcmp_mask_acc.sv
module vcmp_mask_acc #(
  parameter int XLEN = 32,
  localparam int IW  = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            set_en,
  input  logic [IW-1:0]   idx,
  input  logic            hit,
  output logic [XLEN-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask <= '0;
    else if (clear)
      mask <= '0;
    else if (set_en && hit)
      mask[idx] <= 1'b1;
  end

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (mask == '0));

  assert_miss_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !(set_en && hit)) |=> $stable(mask));
endmodule

// File: rtl/vcmp_seq.sv
module vcmp_seq
  import vcmp_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG),
  localparam int IW  = $clog2(XLEN),
  localparam int VW  = $clog2(XLEN + 1) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      funct3,
  input  logic [AW-1:0]   src1_idx,
  input  logic [AW-1:0]   src2_idx,
  input  logic            src1_vec,
  input  logic            src2_vec,
  input  logic [AW-1:0]   pred_dst,
  input  logic [VW-1:0]   vl,
  output logic [AW-1:0]   rd1_addr,
  input  logic [XLEN-1:0] rd1_data,
  output logic [AW-1:0]   rd2_addr,
  input  logic [XLEN-1:0] rd2_data,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [XLEN-1:0] wr_data,
  output logic            busy,
  output logic            done,
  output logic            scalar_take
);
  function automatic logic [VW-1:0] clamp_len(input logic [VW-1:0] req);
    return (req > VW'(XLEN)) ? VW'(XLEN) : req;
  endfunction

  seq_state_t     state_q;
  logic [IW-1:0]  idx_q, last_q;
  logic [2:0]     f3_q;
  logic [AW-1:0]  base_q [2];
  logic [1:0]     vec_q;
  logic [AW-1:0]  dst_q;
  logic           scalar_q;

  logic [VW-1:0]  vl_eff;
  logic           any_vec, accept, vec_accept, scalar_accept, zero_len;
  logic           elem_step, walk_end;
  logic [AW-1:0]  rd_addr_w [2];
  logic           elem_hit;
  logic [XLEN-1:0] mask_w;

  assign vl_eff        = clamp_len(vl);
  assign any_vec       = src1_vec | src2_vec;
  assign accept        = start && (state_q == ST_IDLE);
  assign vec_accept    = accept && any_vec;
  assign scalar_accept = accept && !any_vec;
  assign zero_len      = (vl_eff == '0);
  assign elem_step     = (state_q == ST_WALK);
  assign walk_end      = elem_step && (idx_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      last_q    <= '0;
      f3_q      <= '0;
      base_q[0] <= '0;
      base_q[1] <= '0;
      vec_q     <= '0;
      dst_q     <= '0;
      scalar_q  <= 1'b0;
    end else begin
      scalar_q <= scalar_accept;
      case (state_q)
        ST_IDLE: begin
          if (vec_accept) begin
            f3_q      <= funct3;
            base_q[0] <= src1_idx;
            base_q[1] <= src2_idx;
            vec_q     <= {src2_vec, src1_vec};
            dst_q     <= pred_dst;
            idx_q     <= '0;
            last_q    <= IW'(vl_eff - VW'(1));
            state_q   <= zero_len ? ST_WRITE : ST_WALK;
          end
        end
        ST_WALK: begin
          if (walk_end) state_q <= ST_WRITE;
          else          idx_q   <= idx_q + IW'(1);
        end
        ST_WRITE: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_port
    vcmp_addr_gen #(.NREG(NREG), .IW(IW)) u_addr (
      .base   (base_q[p]),
      .is_vec (vec_q[p]),
      .idx    (idx_q),
      .addr   (rd_addr_w[p])
    );
  end

  assign rd1_addr = rd_addr_w[0];
  assign rd2_addr = rd_addr_w[1];

  vcmp_elem_cmp #(.XLEN(XLEN)) u_cmp (
    .sel (f3_q),
    .a   (rd1_data),
    .b   (rd2_data),
    .hit (elem_hit)
  );

  vcmp_mask_acc #(.XLEN(XLEN)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (vec_accept),
    .set_en (elem_step),
    .idx    (idx_q),
    .hit    (elem_hit),
    .mask   (mask_w)
  );

  assign busy        = elem_step;
  assign wr_en       = (state_q == ST_WRITE);
  assign done        = wr_en;
  assign wr_addr     = dst_q;
  assign wr_data     = mask_w;
  assign scalar_take = scalar_q;

  assert_single_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && wr_en));

  assert_end_then_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    walk_end |=> (wr_en && !busy));

  assert_scalar_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scalar_accept |=> (scalar_take && !busy && !wr_en));

  assert_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_accept && zero_len) |=> (wr_en && wr_data == '0 && !busy));

  assert_hold_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(dst_q) && $stable(f3_q));
endmodule

// File: tb/sim_vcmp_seq.sv
module sim_vcmp_seq;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int AW   = 5;
  localparam int VW   = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] funct3 = '0;
  logic [AW-1:0] src1_idx = '0, src2_idx = '0, pred_dst = '0;
  logic src1_vec = 1'b0, src2_vec = 1'b0;
  logic [VW-1:0] vl = '0;
  logic [AW-1:0] rd1_addr, rd2_addr, wr_addr;
  logic [XLEN-1:0] rd1_data, rd2_data, wr_data;
  logic wr_en, busy, done, scalar_take;
  logic [XLEN-1:0] rf [NREG];

  int n_chk = 0;
  int n_bad = 0;
  int cyc_total = 0;

  always #5 clk = ~clk;

  assign rd1_data = rf[rd1_addr];
  assign rd2_data = rf[rd2_addr];

  vcmp_seq #(.XLEN(XLEN), .NREG(NREG)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .funct3(funct3),
    .src1_idx(src1_idx), .src2_idx(src2_idx), .src1_vec(src1_vec),
    .src2_vec(src2_vec), .pred_dst(pred_dst), .vl(vl),
    .rd1_addr(rd1_addr), .rd1_data(rd1_data), .rd2_addr(rd2_addr),
    .rd2_data(rd2_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .done(done), .scalar_take(scalar_take)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc_total);
      finish_run();
    end
  end

  function automatic logic ref_cmp(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
    logic signed [31:0] sa = a;
    logic signed [31:0] sb = b;
    if (f == 3'b000) return a == b;
    if (f == 3'b001) return a != b;
    if (f == 3'b100) return sa < sb;
    if (f == 3'b101) return !(sa < sb);
    if (f == 3'b110) return a < b;
    if (f == 3'b111) return !(a < b);
    return 1'b0;
  endfunction

  function automatic int eff_len(input int req);
    return (req > XLEN) ? XLEN : req;
  endfunction

  function automatic int ea(input int base, input logic v, input int i);
    return v ? (base + i) % NREG : base;
  endfunction

  function automatic logic [31:0] ref_mask(input logic [2:0] f, input int s1, input int s2,
                                           input logic v1, input logic v2, input int len);
    logic [31:0] m = '0;
    for (int i = 0; i < len; i++)
      m[i] = ref_cmp(f, rf[ea(s1, v1, i)], rf[ea(s2, v2, i)]);
    return m;
  endfunction

  task automatic run_vec(input string tag, input logic [2:0] f, input int s1, input int s2,
                         input logic v1, input logic v2, input int dst, input int req,
                         input logic poke);
    int len = eff_len(req);
    int cyc = 0;
    logic addr_ok = 1'b1;
    logic busy_ok = 1'b1;
    logic [31:0] exp = ref_mask(f, s1, s2, v1, v2, len);
    @(negedge clk);
    funct3 = f; src1_idx = AW'(s1); src2_idx = AW'(s2);
    src1_vec = v1; src2_vec = v2; pred_dst = AW'(dst); vl = VW'(req);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 200) begin
      if (!busy) busy_ok = 1'b0;
      if (rd1_addr != AW'(ea(s1, v1, cyc)) || rd2_addr != AW'(ea(s2, v2, cyc))) addr_ok = 1'b0;
      if (poke && cyc == 1) begin
        start = 1'b1; funct3 = ~f; pred_dst = ~AW'(dst); src1_idx = ~AW'(s1); vl = VW'(3);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check({tag, " R8 latency"}, cyc, len);
    check({tag, " R5 addresses"}, addr_ok, 1'b1);
    check({tag, " R8 busy held"}, busy_ok, 1'b1);
    check({tag, " R8 wr_en"}, wr_en, 1'b1);
    check({tag, " R8 wr_addr"}, wr_addr, dst);
    check({tag, " R6 mask"}, wr_data, exp);
    @(negedge clk);
    check({tag, " R8 done one cycle"}, {busy, done}, 2'b00);
  endtask

  task automatic t_reset();
    check("R8 reset outputs", {busy, done, wr_en, scalar_take}, 4'b0000);
  endtask

  task automatic t_scalar();
    @(negedge clk);
    funct3 = 3'b000; src1_vec = 0; src2_vec = 0; src1_idx = 3; src2_idx = 4;
    pred_dst = 9; vl = 8; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7 scalar_take pulse", {scalar_take, busy, wr_en}, 3'b100);
    @(negedge clk);
    check("R7 scalar_take drops", {scalar_take, busy, wr_en}, 3'b000);
  endtask

  task automatic t_zero_len();
    @(negedge clk);
    funct3 = 3'b000; src1_vec = 1; src2_vec = 1; src1_idx = 8; src2_idx = 8;
    pred_dst = 6; vl = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9 immediate write", {wr_en, busy}, 2'b10);
    check("R9 zero mask", wr_data, 32'h0);
    check("R9 target", wr_addr, 6);
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < NREG; k++) rf[k] = (k * 32'h9E3779B1) ^ (k << 7);
    for (int k = 0; k < 4; k++) rf[16 + k] = rf[8 + k];
    rf[20] = 32'h8000_0000; rf[21] = 32'h7FFF_FFFF; rf[22] = 32'hFFFF_FFFF;
    rf[23] = 32'h0000_0001; rf[24] = 32'h8000_0000; rf[25] = 32'h0;
    rf[2] = 32'h0000_0010;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_vec("R1 eq vv",        3'b000,  8, 16, 1, 1, 7,  8, 0);
    run_vec("R1 ne vs R5",     3'b001,  8,  9, 1, 0, 3,  6, 0);
    run_vec("R2 lt sv",        3'b100,  2, 20, 0, 1, 4,  6, 0);
    run_vec("R2 ge vv",        3'b101, 20, 23, 1, 1, 5,  5, 0);
    run_vec("R3 ltu vv",       3'b110, 20, 23, 1, 1, 10, 5, 0);
    run_vec("R3 geu vs",       3'b111, 20, 2,  1, 0, 11, 6, 0);
    run_vec("R4 rsvd 010",     3'b010,  8, 16, 1, 1, 12, 8, 0);
    run_vec("R4 rsvd 011",     3'b011,  8, 8,  1, 1, 13, 8, 0);
    run_vec("R5 wrap",         3'b110, 29, 3,  1, 1, 14, 7, 0);
    run_vec("R10 clamp",       3'b111,  0, 31, 1, 0, 15, 40, 0);
    run_vec("R6 single elem",  3'b000,  8, 16, 1, 1, 1,  1, 0);
    run_vec("R11 ignore start",3'b100,  5, 21, 1, 0, 17, 9, 1);
    t_scalar();
    t_zero_len();
    finish_run();
  end
endmodule